// File: doc/BRIEF.md
# Bank-Interleaved DRAM Read Scheduler

This block turns a stream of random read requests into commands on a slotted DRAM command bus. Each request carries a bank, a row, a column and a tag. The block opens the row with an activate and later reads the column with auto-precharge, so every bank is closed again after its one read. A read moves 8 beats on a 32-bit data interface, which is 32 bytes. That burst takes two command slots. One slot carries the read, and the scheduler puts the activate for a later request, to a different bank, in the other slot. As long as consecutive requests go to different banks, reads follow each other with no gap.

The scheduler keeps a timer for each bank, covering activate-to-read delay and activate-to-activate delay. It also tracks how many activates fall in a rolling window. If a request would break any of these rules, the scheduler holds it back. Requests are served strictly in the order they were accepted. For each read, the block raises a data-valid strobe with the request's tag at the time the burst is due on the data pins.

Requests enter on a valid/ready port. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` falls only when the input queue is full. The requester must hold its request and fields steady until the transfer happens. There is no back-pressure on the command bus or on the data strobe.

Top module: `dram_rd_sched`

## Requirements
- R1: A request is taken on each clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while the input queue holds FIFO_DEPTH entries, and a request offered then is not lost but taken later.
- R2: `cmd_op` is coded 2'b00 = idle, 2'b01 = activate (`cmd_addr` carries the row), 2'b10 = read with auto-precharge (`cmd_addr` carries the column). Code 2'b11 and explicit precharge never appear. `cmd_bank` and `cmd_addr` are zero with the idle code.
- R3: Every accepted request produces exactly one activate and then one read, both to its bank and with its row and column. Activates and reads each follow acceptance order.
- R4: A read to a bank is on the bus no earlier than T_RCD slots after that bank's activate.
- R5: An activate to a bank is no earlier than T_RC slots after that bank's previous activate. Two requests to one bank back to back have their activates exactly T_RC slots apart, while requests to two different banks can have activates in adjacent slots.
- R6: Any T_FAW consecutive slots hold at most four activates. A fifth activate that is otherwise ready lands exactly T_FAW slots after the first of the four.
- R7: Reads are at least two slots apart, one per burst period. An activate in the slot right after a read targets a different bank.
- R8: When requests rotate over enough banks and T_FAW is at most eight slots, the reads after the first one follow each other every two slots.
- R9: For a read on the bus in slot c, `rd_valid` is high in slots c+RD_LAT and c+RD_LAT+1 (the 8 beats), with `rd_id` equal to that request's tag.
- R10: While `rst_n` is low, only idle commands are driven and `rd_valid` is low. After reset all bank timers and the activate window are idle, so the first request's activate reaches the bus two cycles after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Input queue has room |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Column to read |
| req_id | input | ID_W | Tag returned with the data strobe |
| cmd_op | output | 2 | Command code for this slot |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row for activate, column for read |
| rd_valid | output | 1 | Data burst expected in this slot |
| rd_id | output | ID_W | Tag of the burst in flight |

## Verification
The bench builds the block with 8 banks, T_RCD = 5, T_RC = 12, T_FAW = 8 and RD_LAT = 6. Because T_RCD is odd, each activate and its read land in opposite slots of a period. This lets the full-rate stream reach a steady cadence of one read every two slots. A T_FAW of exactly four burst periods puts the fifth activate on the window boundary, so an off-by-one in the window timer shows up as a stall. A T_RC of 12, below the 16-slot rotation over 8 banks, lets the same-bank tests expose the exact re-activate distance without the window getting in the way.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RDA = 2'b10
  } cmd_e;
endpackage

// File: rtl/dsched_fifo.sv
module dsched_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign push_ready = (count != CW'(DEPTH));
  assign pop_valid  = (count != '0);
  assign pop_data   = mem[rd_ptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_valid && pop_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy stays within the queue
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R1: a lone push grows the queue by one
  a_r1_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/dsched_bank_timers.sv
module dsched_bank_timers #(
  parameter int NBANKS = 16,
  parameter int T_RCD  = 6,
  parameter int T_RC   = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      act_fire,
  input  logic [BANK_W-1:0]         act_bank,
  input  logic                      rd_fire,
  input  logic [BANK_W-1:0]         rd_bank,
  output logic [NBANKS-1:0]         act_ok,
  output logic [NBANKS-1:0]         rd_ok
);
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
  localparam int AW     = $clog2(T_RC + 1);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [AW-1:0] age;
    logic          open;
    logic          hit_act, hit_rd;

    assign hit_act = act_fire && (act_bank == BANK_W'(b));
    assign hit_rd  = rd_fire  && (rd_bank  == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age  <= AW'(T_RC);
        open <= 1'b0;
      end else begin
        if (hit_act)                 age <= AW'(1);
        else if (age != AW'(T_RC))   age <= age + 1'b1;
        if (hit_act)     open <= 1'b1;
        else if (hit_rd) open <= 1'b0;
      end
    end

    assign act_ok[b] = !open && (age == AW'(T_RC));
    assign rd_ok[b]  = open && (age >= AW'(T_RCD));

    // R5: the scheduler never activates a bank still open or inside T_RC
    a_r5_trc_guard: assert property (@(posedge clk) disable iff (!rst_n)
      hit_act |-> (!open && age == AW'(T_RC)));
    // R4: a read only follows an activate by at least T_RCD
    a_r4_trcd_guard: assert property (@(posedge clk) disable iff (!rst_n)
      hit_rd |-> (open && age >= AW'(T_RCD)));
  end
endmodule

// File: rtl/dsched_faw.sv
module dsched_faw #(
  parameter int T_FAW   = 24,
  parameter int ACT_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_fire,
  output logic act_ok
);
  localparam int CW = $clog2(T_FAW + 1);
  localparam int SW = (ACT_MAX > 1) ? $clog2(ACT_MAX) : 1;

  logic [CW-1:0]      remain [ACT_MAX];
  logic [ACT_MAX-1:0] busy;
  logic [SW-1:0]      sel;

  always_comb begin
    sel = '0;
    for (int i = ACT_MAX - 1; i >= 0; i--) begin
      busy[i] = (remain[i] != '0);
      if (!busy[i]) sel = SW'(i);
    end
  end

  assign act_ok = !(&busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ACT_MAX; i++) remain[i] <= '0;
    end else begin
      for (int i = 0; i < ACT_MAX; i++) begin
        if (act_fire && sel == SW'(i)) remain[i] <= CW'(T_FAW - 1);
        else if (remain[i] != '0)      remain[i] <= remain[i] - 1'b1;
      end
    end
  end

  // R6: an activate only issues while the window still has a free place
  a_r6_faw_window: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> ($countones(busy) < ACT_MAX));
endmodule

// File: rtl/dsched_rd_pipe.sv
module dsched_rd_pipe #(
  parameter int RD_LAT      = 10,
  parameter int BURST_SLOTS = 2,
  parameter int ID_W        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [ID_W-1:0] id,
  output logic            out_valid,
  output logic [ID_W-1:0] out_id
);
  localparam int L = RD_LAT + BURST_SLOTS;

  logic [L-1:0]      sh_v;
  logic [ID_W-1:0]   sh_id [L];
  logic [BURST_SLOTS-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_v <= '0;
      for (int k = 0; k < L; k++) sh_id[k] <= '0;
    end else begin
      sh_v     <= {sh_v[L-2:0], fire};
      sh_id[0] <= id;
      for (int k = 1; k < L; k++) sh_id[k] <= sh_id[k-1];
    end
  end

  assign win       = sh_v[L-1 -: BURST_SLOTS];
  assign out_valid = |win;

  always_comb begin
    out_id = '0;
    for (int k = RD_LAT; k < L; k++)
      if (sh_v[k]) out_id = sh_id[k];
  end

  // R9: bursts never overlap on the data strobe
  a_r9_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));
  // R9: a burst lasts beyond its first slot
  a_r9_two_slots: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid);
endmodule

// File: rtl/dram_rd_sched.sv
module dram_rd_sched
  import dsched_pkg::*;
#(
  parameter int NBANKS      = 16,
  parameter int ROW_W       = 14,
  parameter int COL_W       = 7,
  parameter int ID_W        = 4,
  parameter int T_RCD       = 6,
  parameter int T_RC        = 20,
  parameter int T_FAW       = 24,
  parameter int RD_LAT      = 10,
  parameter int BURST_SLOTS = 2,
  parameter int FIFO_DEPTH  = 4,
  parameter int PEND_DEPTH  = 4,
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [ID_W-1:0]   req_id,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_valid,
  output logic [ID_W-1:0]   rd_id
);
  localparam int IN_W  = BANK_W + ROW_W + COL_W + ID_W;
  localparam int PD_W  = BANK_W + COL_W + ID_W;
  localparam int GAP_W = $clog2(BURST_SLOTS + 1);

  // accepted-request queue
  logic              in_valid;
  logic [IN_W-1:0]   in_data;
  logic [BANK_W-1:0] in_bank;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  in_col;
  logic [ID_W-1:0]   in_id;

  // activated-awaiting-read queue
  logic              pend_ready, pend_valid;
  logic [PD_W-1:0]   pend_data;
  logic [BANK_W-1:0] pend_bank;
  logic [COL_W-1:0]  pend_col;
  logic [ID_W-1:0]   pend_id;

  logic [NBANKS-1:0] bank_act_ok, bank_rd_ok;
  logic              faw_ok;
  logic              act_fire, rd_fire;
  logic [GAP_W-1:0]  rd_gap;
  logic              last_rd_v;
  logic [BANK_W-1:0] last_rd_bank;
  logic              spare_clash;
  cmd_e              op_q;

  dsched_fifo #(.W(IN_W), .DEPTH(FIFO_DEPTH)) u_in_q (
    .clk, .rst_n,
    .push_valid (req_valid),
    .push_ready (req_ready),
    .push_data  ({req_bank, req_row, req_col, req_id}),
    .pop_valid  (in_valid),
    .pop_ready  (act_fire),
    .pop_data   (in_data)
  );

  assign in_bank = in_data[IN_W-1 -: BANK_W];
  assign in_row  = in_data[ROW_W+COL_W+ID_W-1 -: ROW_W];
  assign in_col  = in_data[COL_W+ID_W-1 -: COL_W];
  assign in_id   = in_data[ID_W-1:0];

  dsched_fifo #(.W(PD_W), .DEPTH(PEND_DEPTH)) u_pend_q (
    .clk, .rst_n,
    .push_valid (act_fire),
    .push_ready (pend_ready),
    .push_data  ({in_bank, in_col, in_id}),
    .pop_valid  (pend_valid),
    .pop_ready  (rd_fire),
    .pop_data   (pend_data)
  );

  assign pend_bank = pend_data[PD_W-1 -: BANK_W];
  assign pend_col  = pend_data[COL_W+ID_W-1 -: COL_W];
  assign pend_id   = pend_data[ID_W-1:0];

  dsched_bank_timers #(.NBANKS(NBANKS), .T_RCD(T_RCD), .T_RC(T_RC)) u_timers (
    .clk, .rst_n,
    .act_fire (act_fire),
    .act_bank (in_bank),
    .rd_fire  (rd_fire),
    .rd_bank  (pend_bank),
    .act_ok   (bank_act_ok),
    .rd_ok    (bank_rd_ok)
  );

  dsched_faw #(.T_FAW(T_FAW), .ACT_MAX(4)) u_faw (
    .clk, .rst_n,
    .act_fire (act_fire),
    .act_ok   (faw_ok)
  );

  // issue decision: a due read owns the slot, an activate takes the spare one
  assign rd_fire     = pend_valid && bank_rd_ok[pend_bank] && (rd_gap >= GAP_W'(BURST_SLOTS));
  assign spare_clash = last_rd_v && (last_rd_bank == in_bank);
  assign act_fire    = in_valid && pend_ready && !rd_fire && faw_ok &&
                       bank_act_ok[in_bank] && !spare_clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_gap       <= GAP_W'(BURST_SLOTS);
      last_rd_v    <= 1'b0;
      last_rd_bank <= '0;
    end else begin
      if (rd_fire)                            rd_gap <= GAP_W'(1);
      else if (rd_gap != GAP_W'(BURST_SLOTS)) rd_gap <= rd_gap + 1'b1;
      last_rd_v    <= rd_fire;
      last_rd_bank <= pend_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= CMD_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
    end else if (rd_fire) begin
      op_q     <= CMD_RDA;
      cmd_bank <= pend_bank;
      cmd_addr <= ADDR_W'(pend_col);
    end else if (act_fire) begin
      op_q     <= CMD_ACT;
      cmd_bank <= in_bank;
      cmd_addr <= ADDR_W'(in_row);
    end else begin
      op_q     <= CMD_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
    end
  end

  assign cmd_op = op_q;

  dsched_rd_pipe #(.RD_LAT(RD_LAT), .BURST_SLOTS(BURST_SLOTS), .ID_W(ID_W)) u_rd_pipe (
    .clk, .rst_n,
    .fire      (rd_fire),
    .id        (pend_id),
    .out_valid (rd_valid),
    .out_id    (rd_id)
  );

  // R2: only the three defined codes reach the bus
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op != 2'b11);
  // R2: idle slots carry no bank or address
  a_r2_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b00) |-> (cmd_bank == '0 && cmd_addr == '0));
  // R7: two reads never share a burst period
  a_r7_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b10) |=> (cmd_op != 2'b10));
  // R7: the spare-slot activate goes to another bank
  a_r7_spare_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b01 && $past(cmd_op) == 2'b10) |-> (cmd_bank != $past(cmd_bank)));
  // R10: reset leaves the data strobe quiet
  a_r10_strobe_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_valid);
endmodule

// File: tb/tb_dram_rd_sched.sv
`timescale 1ns/1ps
module tb_dram_rd_sched;
  localparam int NB    = 8;
  localparam int ROWW  = 12;
  localparam int COLW  = 6;
  localparam int IDW   = 4;
  localparam int TRCD  = 5;
  localparam int TRC   = 12;
  localparam int TFAW  = 8;
  localparam int RL    = 6;
  localparam int BW    = 3;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [BW-1:0]   req_bank = '0;
  logic [ROWW-1:0] req_row = '0;
  logic [COLW-1:0] req_col = '0;
  logic [IDW-1:0]  req_id = '0;
  logic [1:0]      cmd_op;
  logic [BW-1:0]   cmd_bank;
  logic [AW-1:0]   cmd_addr;
  logic            rd_valid;
  logic [IDW-1:0]  rd_id;

  always #10 clk = ~clk;

  dram_rd_sched #(
    .NBANKS(NB), .ROW_W(ROWW), .COL_W(COLW), .ID_W(IDW),
    .T_RCD(TRCD), .T_RC(TRC), .T_FAW(TFAW), .RD_LAT(RL),
    .BURST_SLOTS(2), .FIFO_DEPTH(4), .PEND_DEPTH(4)
  ) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_bank, .req_row, .req_col,
    .req_id, .cmd_op, .cmd_bank, .cmd_addr, .rd_valid, .rd_id
  );

  typedef struct {int bank; int row; int col; int id;} req_t;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  bit saw_not_ready = 0;
  req_t act_q[$];
  req_t rd_q[$];
  int act_log[$];
  int rd_log[$];
  int acc_log[$];
  int faw_hist[$];
  int lastact[NB];
  int last_rd_cyc = -100;
  int last_rd_bank = -1;
  bit exp_v[64];
  int exp_id[64];
  int pend_dv = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // monitor: timing rules, scoreboard pops, data strobe
  always @(negedge clk) begin
    int s;
    req_t e;
    if (rst_n) begin
      s = cyc % 64;
      if (exp_v[s] || rd_valid) begin
        check(rd_valid == exp_v[s], "R9 strobe", rd_valid, exp_v[s]);
        if (exp_v[s]) begin
          check(rd_id == IDW'(exp_id[s]), "R9 tag", rd_id, exp_id[s]);
          pend_dv--;
        end
        exp_v[s] = 0;
      end
      case (cmd_op)
        2'b00: if (cmd_bank != 0 || cmd_addr != 0)
                 check(0, "R2 idle fields", int'(cmd_addr), 0);
        2'b01: begin
          if (act_q.size() == 0) check(0, "R3 extra activate", int'(cmd_bank), -1);
          else begin
            e = act_q.pop_front();
            check(int'(cmd_bank) == e.bank, "R3 act bank", cmd_bank, e.bank);
            check(int'(cmd_addr) == e.row, "R3 act row", cmd_addr, e.row);
          end
          check(cyc - lastact[cmd_bank] >= TRC, "R5 tRC", cyc - lastact[cmd_bank], TRC);
          if (faw_hist.size() == 4) begin
            check(cyc - faw_hist[0] >= TFAW, "R6 window", cyc - faw_hist[0], TFAW);
            void'(faw_hist.pop_front());
          end
          faw_hist.push_back(cyc);
          if (last_rd_cyc == cyc - 1)
            check(int'(cmd_bank) != last_rd_bank, "R7 spare bank", cmd_bank, -1);
          lastact[cmd_bank] = cyc;
          act_log.push_back(cyc);
        end
        2'b10: begin
          if (rd_q.size() == 0) check(0, "R3 extra read", int'(cmd_bank), -1);
          else begin
            e = rd_q.pop_front();
            check(int'(cmd_bank) == e.bank, "R3 read bank", cmd_bank, e.bank);
            check(int'(cmd_addr) == e.col, "R3 read col", cmd_addr, e.col);
            exp_v[(cyc + RL) % 64] = 1;
            exp_id[(cyc + RL) % 64] = e.id;
            exp_v[(cyc + RL + 1) % 64] = 1;
            exp_id[(cyc + RL + 1) % 64] = e.id;
            pend_dv += 2;
          end
          check(cyc - lastact[cmd_bank] >= TRCD, "R4 tRCD", cyc - lastact[cmd_bank], TRCD);
          check(cyc - last_rd_cyc >= 2, "R7 read spacing", cyc - last_rd_cyc, 2);
          last_rd_cyc = cyc;
          last_rd_bank = int'(cmd_bank);
          rd_log.push_back(cyc);
        end
        default: check(0, "R2 code", cmd_op, 0);
      endcase
    end
  end

  task automatic send(input int b, input int r, input int c, input int i);
    req_t x;
    x.bank = b; x.row = r; x.col = c; x.id = i;
    @(negedge clk);
    req_valid = 1'b1;
    req_bank = BW'(b);
    req_row = ROWW'(r);
    req_col = COLW'(c);
    req_id = IDW'(i);
    while (!req_ready) begin
      saw_not_ready = 1;
      @(negedge clk);
    end
    acc_log.push_back(cyc);
    act_q.push_back(x);
    rd_q.push_back(x);
    @(posedge clk);
  endtask

  task automatic stop_and_drain();
    @(negedge clk);
    req_valid = 1'b0;
    while (act_q.size() != 0 || rd_q.size() != 0 || pend_dv > 0) @(negedge clk);
    repeat (TRC + 4) @(negedge clk);
  endtask

  task automatic clear_logs();
    act_log.delete();
    rd_log.delete();
    acc_log.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) lastact[b] = -1000;
    for (int s = 0; s < 64; s++) begin exp_v[s] = 0; exp_id[s] = 0; end
    // R10: reset state
    repeat (4) begin
      @(negedge clk);
      check(cmd_op == 2'b00, "R10 idle in reset", cmd_op, 0);
      check(rd_valid == 1'b0, "R10 strobe in reset", rd_valid, 0);
    end
    rst_n = 1'b1;

    // R8/R6/R10: rotating banks at full rate
    clear_logs();
    for (int i = 0; i < 16; i++) send(i % NB, 100 + i, i, i % 16);
    stop_and_drain();
    check(act_log.size() == 16, "R3 act count", act_log.size(), 16);
    check(rd_log.size() == 16, "R3 read count", rd_log.size(), 16);
    check(act_log[0] == acc_log[0] + 2, "R10 first activate", act_log[0], acc_log[0] + 2);
    check(act_log[4] - act_log[0] == TFAW, "R6 fifth activate", act_log[4] - act_log[0], TFAW);
    for (int k = 1; k < 16; k++)
      check(rd_log[k] - rd_log[k-1] == 2, "R8 read cadence", rd_log[k] - rd_log[k-1], 2);

    // R5: same bank twice
    clear_logs();
    send(3, 7, 1, 1);
    send(3, 9, 2, 2);
    stop_and_drain();
    check(act_log[1] - act_log[0] == TRC, "R5 same-bank gap", act_log[1] - act_log[0], TRC);

    // R5: two different banks
    clear_logs();
    send(5, 11, 3, 3);
    send(6, 12, 4, 4);
    stop_and_drain();
    check(act_log[1] - act_log[0] == 1, "R5 other-bank gap", act_log[1] - act_log[0], 1);

    // R1: back-pressure with a repeated bank
    clear_logs();
    saw_not_ready = 0;
    for (int i = 0; i < 8; i++) send(2, 20 + i, 40 + i, 8 + i);
    stop_and_drain();
    check(saw_not_ready, "R1 ready drops when full", saw_not_ready, 1);
    check(rd_log.size() == 8, "R1 all taken", rd_log.size(), 8);
    for (int k = 1; k < 8; k++)
      check(act_log[k] - act_log[k-1] == TRC, "R5 repeated bank", act_log[k] - act_log[k-1], TRC);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule